// File: doc/BRIEF.md
# Accumulator Execution Unit with Processor Status Flags

This block is the data-path core of a small 8-bit accumulator-style processor. It owns the accumulator, two index registers and an 8-bit processor status register. On every clock edge where the enable input is high, it takes one operation code and one 8-bit memory operand. It then updates its registers and flags, and it registers a result byte for the memory-write side of the processor. The status byte and both index registers are driven out continuously. Address generation, branching, the stack pointer and instruction fetch belong to other blocks. A value fetched from the stack is simply presented on the operand input.

The operation input uses a compact internal code grouped by function, not the raw instruction byte. Add and subtract honour the decimal flag. When that flag is set, the arithmetic takes a separate packed-decimal path. Every output is a register, so the effect of an operation accepted at one clock edge is visible after that edge.

Top module: `acc_alu`

## Requirements
- R1: Reset (active-low `rst_ni`) sets the accumulator, X, Y and the result register to 0x00 and the status register to 0x22. Status bits are: 0 carry, 1 zero, 2 interrupt mask, 3 decimal, 4 break, 5 always one, 6 overflow, 7 negative.
- R2: With `en_i` low, or with an operation code of 45 to 63 (codes 0 to 44 follow the order of `op_e` in the package, and 0 is no-operation), no register and no output changes.
- R3: With the decimal flag clear, add-with-carry computes A+M+C into A and the result port. C is set when the sum exceeds 255. V is set when A and M share a sign that the result does not. Z and N follow the result.
- R4: With the decimal flag clear, subtract-with-borrow computes A−M−(1−C) into A and the result port. C is 1 when no borrow occurs. V = (A7^M7)&(A7^R7). Z and N follow the result.
- R5: With the decimal flag set, add and subtract work nibble by nibble, and each nibble is corrected by ±6 when it leaves 0..9. C is the carry or no-borrow of the upper nibble. Z and N follow the corrected result. V follows the binary rule.
- R6: AND, OR and XOR with the operand write A and the result port, and update Z and N.
- R7: Shift-left, shift-right, rotate-left and rotate-right act either on A, writing A and the result port, or on the operand, writing only the result port. Bit 7 (left) or bit 0 (right) goes to C. A rotate brings the old C into bit 0 (left) or bit 7 (right). Z and N follow the shifted value.
- R8: Increment and decrement of the operand drive the result port and set Z and N. Increment and decrement of X or Y set Z and N but leave the result port unchanged.
- R9: Compare against A, X or Y sets Z and N from (register − operand) modulo 256. It sets C when the register is unsigned greater than or equal to the operand. No register or result changes.
- R10: Bit test sets Z from (A & operand), copies operand bit 7 to N and operand bit 6 to V, and changes neither A, X, Y nor the result port.
- R11: Load of A drives the result port. Loads of X and Y, the stack-value-to-X transfer, and all transfers between A and X or Y leave the result port unchanged. All of them update Z and N from the moved value.
- R12: Push-accumulator and store-accumulator drive A onto the result port with no flag change. Pull-accumulator loads A and the result port from the operand and updates Z and N.
- R13: Pull-status and return-from-interrupt load the status register from the operand with bit 5 forced to 1. Break sets bit 4. The flag operations set or clear C, I or D, or clear V, and touch nothing else. Status bit 5 reads 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Accept the operation on this edge |
| op_i | input | 6 | Internal operation code (`op_e`) |
| operand_i | input | 8 | Memory or stack operand |
| result_o | output | 8 | Registered result byte |
| status_o | output | 8 | Processor status register |
| x_o | output | 8 | Index register X |
| y_o | output | 8 | Index register Y |

## Verification
The hardest case to reach from the ports is decimal arithmetic that straddles a nibble boundary with a given incoming carry. It requires the set-decimal operation to have run first, the accumulator to have been loaded, and carry to have been put in a known state. Directed sequences chain set-decimal, a carry operation, a load and then add or subtract on 0x99+0x01 and 0x00−0x01. The random phase draws the set- and clear-decimal codes as often as any other, so about half of its arithmetic runs in decimal mode on arbitrary and non-decimal operand patterns.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 6;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FI = 2;
  localparam int FD = 3;
  localparam int FB = 4;
  localparam int FU = 5;
  localparam int FV = 6;
  localparam int FN = 7;

  typedef enum logic [OPW-1:0] {
    OP_NOP, OP_ADC, OP_SBC, OP_AND, OP_ORA, OP_EOR,
    OP_ASLA, OP_ASLM, OP_LSRA, OP_LSRM, OP_ROLA, OP_ROLM, OP_RORA, OP_RORM,
    OP_INCM, OP_DECM, OP_INX, OP_INY, OP_DEX, OP_DEY,
    OP_CMP, OP_CPX, OP_CPY, OP_BIT,
    OP_LDA, OP_LDX, OP_LDY, OP_TAX, OP_TAY, OP_TXA, OP_TYA, OP_TSX,
    OP_PHA, OP_STA, OP_PLA, OP_PLP, OP_RTI, OP_BRK,
    OP_CLC, OP_SEC, OP_CLI, OP_SEI, OP_CLD, OP_SED, OP_CLV
  } op_e;

  localparam int N_OPS = 45;

  typedef enum logic [1:0] {SH_ASL, SH_LSR, SH_ROL, SH_ROR} shift_e;

  function automatic logic [DW-1:0] with_zn(logic [DW-1:0] p, logic [DW-1:0] v);
    logic [DW-1:0] q;
    q     = p;
    q[FZ] = (v == '0);
    q[FN] = v[DW-1];
    return q;
  endfunction

  function automatic logic add_ovf(logic a_msb, logic m_msb, logic r_msb);
    return (a_msb == m_msb) && (r_msb != a_msb);
  endfunction

  function automatic logic sub_ovf(logic a_msb, logic m_msb, logic r_msb);
    return (a_msb ^ m_msb) & (a_msb ^ r_msb);
  endfunction
endpackage

// File: rtl/alu_bin_arith.sv
`timescale 1ns/1ps
module alu_bin_arith
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  logic [DW-1:0] m_eff;
  logic [DW:0]   sum;

  assign m_eff = sub_i ? ~m_i : m_i;
  assign sum   = {1'b0, a_i} + {1'b0, m_eff} + {{DW{1'b0}}, c_i};
  assign res_o = sum[DW-1:0];
  assign c_o   = sum[DW];
  assign v_o   = sub_i ? sub_ovf(a_i[DW-1], m_i[DW-1], sum[DW-1])
                       : add_ovf(a_i[DW-1], m_i[DW-1], sum[DW-1]);
endmodule

// File: rtl/alu_dec_arith.sv
`timescale 1ns/1ps
module alu_dec_arith
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam logic [NW:0]   NINE = (NW+1)'(9);
  localparam logic [NW-1:0] SIX  = NW'(6);

  logic [NW:0]   lo5, hi5;
  logic          lo_cy;
  logic [NW-1:0] lo_fix, hi_fix;

  always_comb begin
    if (sub_i) begin
      lo5    = {1'b0, a_i[NW-1:0]} - {1'b0, m_i[NW-1:0]} - {{NW{1'b0}}, ~c_i};
      lo_cy  = lo5[NW];
      lo_fix = lo_cy ? (lo5[NW-1:0] - SIX) : lo5[NW-1:0];
      hi5    = {1'b0, a_i[DW-1:NW]} - {1'b0, m_i[DW-1:NW]} - {{NW{1'b0}}, lo_cy};
      hi_fix = hi5[NW] ? (hi5[NW-1:0] - SIX) : hi5[NW-1:0];
      c_o    = ~hi5[NW];
    end else begin
      lo5    = {1'b0, a_i[NW-1:0]} + {1'b0, m_i[NW-1:0]} + {{NW{1'b0}}, c_i};
      lo_cy  = (lo5 > NINE);
      lo_fix = lo_cy ? (lo5[NW-1:0] + SIX) : lo5[NW-1:0];
      hi5    = {1'b0, a_i[DW-1:NW]} + {1'b0, m_i[DW-1:NW]} + {{NW{1'b0}}, lo_cy};
      hi_fix = (hi5 > NINE) ? (hi5[NW-1:0] + SIX) : hi5[NW-1:0];
      c_o    = (hi5 > NINE);
    end
    res_o = {hi_fix, lo_fix};
  end
endmodule

// File: rtl/alu_shift_unit.sv
`timescale 1ns/1ps
module alu_shift_unit
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] val_i,
  input  logic          c_i,
  input  shift_e        kind_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  always_comb begin
    case (kind_i)
      SH_ASL: begin res_o = {val_i[DW-2:0], 1'b0}; c_o = val_i[DW-1]; end
      SH_LSR: begin res_o = {1'b0, val_i[DW-1:1]}; c_o = val_i[0];    end
      SH_ROL: begin res_o = {val_i[DW-2:0], c_i};  c_o = val_i[DW-1]; end
      default: begin res_o = {c_i, val_i[DW-1:1]}; c_o = val_i[0];    end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter logic [7:0] RST_STATUS = 8'h22
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [5:0] op_i,
  input  logic [7:0] operand_i,
  output logic [7:0] result_o,
  output logic [7:0] status_o,
  output logic [7:0] x_o,
  output logic [7:0] y_o
);
  logic [DW-1:0] a_q, x_q, y_q, p_q, r_q;
  logic [DW-1:0] a_n, x_n, y_n, p_n, r_n;
  op_e           op;
  logic          op_known;
  logic          dec_mode;

  assign op       = op_e'(op_i);
  assign op_known = (int'(op_i) < N_OPS);
  assign dec_mode = p_q[FD];

  // arithmetic units
  logic [DW-1:0] bin_res, dec_res, arith_res;
  logic          bin_c, bin_v, dec_c, arith_c, is_sub;

  assign is_sub = (op == OP_SBC);

  alu_bin_arith u_bin (
    .a_i(a_q), .m_i(operand_i), .c_i(p_q[FC]), .sub_i(is_sub),
    .res_o(bin_res), .c_o(bin_c), .v_o(bin_v)
  );

  alu_dec_arith u_dec (
    .a_i(a_q), .m_i(operand_i), .c_i(p_q[FC]), .sub_i(is_sub),
    .res_o(dec_res), .c_o(dec_c)
  );

  assign arith_res = dec_mode ? dec_res : bin_res;
  assign arith_c   = dec_mode ? dec_c   : bin_c;

  // shift unit: source picks accumulator or operand
  logic          sh_on_acc;
  shift_e        sh_kind;
  logic [DW-1:0] sh_src, sh_res;
  logic          sh_c;

  always_comb begin
    sh_on_acc = (op == OP_ASLA) || (op == OP_LSRA) || (op == OP_ROLA) || (op == OP_RORA);
    case (op)
      OP_LSRA, OP_LSRM: sh_kind = SH_LSR;
      OP_ROLA, OP_ROLM: sh_kind = SH_ROL;
      OP_RORA, OP_RORM: sh_kind = SH_ROR;
      default:          sh_kind = SH_ASL;
    endcase
  end

  assign sh_src = sh_on_acc ? a_q : operand_i;

  alu_shift_unit u_shift (
    .val_i(sh_src), .c_i(p_q[FC]), .kind_i(sh_kind),
    .res_o(sh_res), .c_o(sh_c)
  );

  // comparator
  logic [DW-1:0] cmp_reg;
  logic [DW:0]   cmp_diff;

  assign cmp_reg  = (op == OP_CPX) ? x_q : (op == OP_CPY) ? y_q : a_q;
  assign cmp_diff = {1'b0, cmp_reg} - {1'b0, operand_i};

  // next-state selection
  logic [DW-1:0] t;

  always_comb begin
    a_n = a_q; x_n = x_q; y_n = y_q; p_n = p_q; r_n = r_q;
    t   = '0;
    if (en_i && op_known) begin
      case (op)
        OP_ADC, OP_SBC: begin
          a_n = arith_res; r_n = arith_res;
          p_n = with_zn(p_q, arith_res);
          p_n[FC] = arith_c; p_n[FV] = bin_v;
        end
        OP_AND, OP_ORA, OP_EOR: begin
          t   = (op == OP_AND) ? (a_q & operand_i) :
                (op == OP_ORA) ? (a_q | operand_i) : (a_q ^ operand_i);
          a_n = t; r_n = t;
          p_n = with_zn(p_q, t);
        end
        OP_ASLA, OP_LSRA, OP_ROLA, OP_RORA: begin
          a_n = sh_res; r_n = sh_res;
          p_n = with_zn(p_q, sh_res); p_n[FC] = sh_c;
        end
        OP_ASLM, OP_LSRM, OP_ROLM, OP_RORM: begin
          r_n = sh_res;
          p_n = with_zn(p_q, sh_res); p_n[FC] = sh_c;
        end
        OP_INCM: begin t = operand_i + 1'b1; r_n = t; p_n = with_zn(p_q, t); end
        OP_DECM: begin t = operand_i - 1'b1; r_n = t; p_n = with_zn(p_q, t); end
        OP_INX:  begin x_n = x_q + 1'b1; p_n = with_zn(p_q, x_n); end
        OP_DEX:  begin x_n = x_q - 1'b1; p_n = with_zn(p_q, x_n); end
        OP_INY:  begin y_n = y_q + 1'b1; p_n = with_zn(p_q, y_n); end
        OP_DEY:  begin y_n = y_q - 1'b1; p_n = with_zn(p_q, y_n); end
        OP_CMP, OP_CPX, OP_CPY: begin
          p_n = with_zn(p_q, cmp_diff[DW-1:0]);
          p_n[FC] = ~cmp_diff[DW];
        end
        OP_BIT: begin
          p_n[FZ] = ((a_q & operand_i) == '0);
          p_n[FN] = operand_i[DW-1];
          p_n[FV] = operand_i[DW-2];
        end
        OP_LDA, OP_PLA: begin a_n = operand_i; r_n = operand_i; p_n = with_zn(p_q, operand_i); end
        OP_LDX, OP_TSX: begin x_n = operand_i; p_n = with_zn(p_q, operand_i); end
        OP_LDY: begin y_n = operand_i; p_n = with_zn(p_q, operand_i); end
        OP_TAX: begin x_n = a_q; p_n = with_zn(p_q, a_q); end
        OP_TAY: begin y_n = a_q; p_n = with_zn(p_q, a_q); end
        OP_TXA: begin a_n = x_q; p_n = with_zn(p_q, x_q); end
        OP_TYA: begin a_n = y_q; p_n = with_zn(p_q, y_q); end
        OP_PHA, OP_STA: r_n = a_q;
        OP_PLP, OP_RTI: begin p_n = operand_i; p_n[FU] = 1'b1; end
        OP_BRK: p_n[FB] = 1'b1;
        OP_CLC: p_n[FC] = 1'b0;
        OP_SEC: p_n[FC] = 1'b1;
        OP_CLI: p_n[FI] = 1'b0;
        OP_SEI: p_n[FI] = 1'b1;
        OP_CLD: p_n[FD] = 1'b0;
        OP_SED: p_n[FD] = 1'b1;
        OP_CLV: p_n[FV] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; x_q <= '0; y_q <= '0; r_q <= '0; p_q <= RST_STATUS;
    end else begin
      a_q <= a_n; x_q <= x_n; y_q <= y_n; r_q <= r_n; p_q <= p_n;
    end
  end

  assign result_o = r_q;
  assign status_o = p_q;
  assign x_o      = x_q;
  assign y_o      = y_q;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [5:0] op_i,
  input logic [7:0] operand_i,
  input logic [7:0] result_o,
  input logic [7:0] status_o,
  input logic [7:0] x_o,
  input logic [7:0] y_o,
  input logic       op_known
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(result_o) && $stable(status_o) && $stable(x_o) && $stable(y_o)); // R2

  AST_UNKNOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !op_known |=> $stable(result_o) && $stable(status_o) && $stable(x_o) && $stable(y_o)); // R2

  AST_INDEX_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_INX || op_i == OP_DEX || op_i == OP_INY || op_i == OP_DEY)
    |=> $stable(result_o)); // R8

  AST_CPX_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_CPX |=> status_o[FC] == ($past(x_o) >= $past(operand_i))); // R9

  AST_CPY_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_CPY |=> status_o[FC] == ($past(y_o) >= $past(operand_i)) && $stable(y_o)); // R9

  AST_BIT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_BIT |=> status_o[7:6] == $past(operand_i[7:6])
      && $stable(x_o) && $stable(y_o) && $stable(result_o)); // R10

  AST_PULL_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_PLP || op_i == OP_RTI) |=> status_o == ($past(operand_i) | 8'h20)); // R13

  AST_BREAK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == OP_BRK |=> status_o[FB] && $stable(result_o)); // R13

  AST_BIT5_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FU]); // R13

  AST_TRANSFER_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == OP_TXA || op_i == OP_TYA || op_i == OP_LDX || op_i == OP_LDY)
    |=> $stable(result_o)); // R11
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i), .operand_i(operand_i),
  .result_o(result_o), .status_o(status_o), .x_o(x_o), .y_o(y_o), .op_known(op_known)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  import acc_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [5:0] op = '0;
  logic [7:0] m = '0;
  logic [7:0] res, st, xo, yo;

  acc_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .operand_i(m),
    .result_o(res), .status_o(st), .x_o(xo), .y_o(yo)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int ea, ex, ey, ep, er;

  function automatic int put(int p, int b, int v);
    return v ? (p | (1 << b)) : (p & ~(1 << b));
  endfunction

  function automatic int zn(int p, int v);
    p = put(p, 1, (v & 255) == 0);
    return put(p, 7, (v & 128) != 0);
  endfunction

  function automatic string tag_of(bit e, int o);
    if (!e || o >= N_OPS) return "R2";
    case (op_e'(o[5:0]))
      OP_ADC: return (ep & 8) ? "R5" : "R3";
      OP_SBC: return (ep & 8) ? "R5" : "R4";
      OP_AND, OP_ORA, OP_EOR: return "R6";
      OP_ASLA, OP_ASLM, OP_LSRA, OP_LSRM, OP_ROLA, OP_ROLM, OP_RORA, OP_RORM: return "R7";
      OP_INCM, OP_DECM, OP_INX, OP_INY, OP_DEX, OP_DEY: return "R8";
      OP_CMP, OP_CPX, OP_CPY: return "R9";
      OP_BIT: return "R10";
      OP_LDA, OP_LDX, OP_LDY, OP_TAX, OP_TAY, OP_TXA, OP_TYA, OP_TSX: return "R11";
      OP_PHA, OP_STA, OP_PLA: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic model(bit e, int o, int mm);
    int c, s, lo, hi, lc, hc, r, v;
    if (!e || o >= N_OPS) return;
    c = ep & 1;
    case (op_e'(o[5:0]))
      OP_ADC: begin
        s = ea + mm + c;
        v = ((~(ea ^ mm)) & (ea ^ s) & 128) != 0;
        if (ep & 8) begin
          lo = (ea & 15) + (mm & 15) + c; lc = 0;
          if (lo > 9) begin lo += 6; lc = 1; end
          hi = (ea >> 4) + (mm >> 4) + lc; hc = 0;
          if (hi > 9) begin hi += 6; hc = 1; end
          r = ((hi & 15) << 4) | (lo & 15);
        end else begin r = s & 255; hc = s > 255; end
        ea = r; er = r; ep = put(put(zn(ep, r), 0, hc), 6, v);
      end
      OP_SBC: begin
        s = ea - mm - (1 - c);
        v = ((ea ^ mm) & (ea ^ s) & 128) != 0;
        if (ep & 8) begin
          lo = (ea & 15) - (mm & 15) - (1 - c); lc = 0;
          if (lo < 0) begin lo -= 6; lc = 1; end
          hi = (ea >> 4) - (mm >> 4) - lc; hc = 0;
          if (hi < 0) begin hi -= 6; hc = 1; end
          r = ((hi & 15) << 4) | (lo & 15);
          hc = !hc;
        end else begin r = s & 255; hc = s >= 0; end
        ea = r; er = r; ep = put(put(zn(ep, r), 0, hc), 6, v);
      end
      OP_AND: begin ea = ea & mm; er = ea; ep = zn(ep, ea); end
      OP_ORA: begin ea = ea | mm; er = ea; ep = zn(ep, ea); end
      OP_EOR: begin ea = ea ^ mm; er = ea; ep = zn(ep, ea); end
      OP_ASLA, OP_ASLM, OP_ROLA, OP_ROLM: begin
        s = (o == OP_ASLA || o == OP_ROLA) ? ea : mm;
        r = ((s << 1) & 255) | ((o == OP_ROLA || o == OP_ROLM) ? c : 0);
        ep = put(zn(ep, r), 0, s >> 7); er = r;
        if (o == OP_ASLA || o == OP_ROLA) ea = r;
      end
      OP_LSRA, OP_LSRM, OP_RORA, OP_RORM: begin
        s = (o == OP_LSRA || o == OP_RORA) ? ea : mm;
        r = (s >> 1) | ((o == OP_RORA || o == OP_RORM) ? (c << 7) : 0);
        ep = put(zn(ep, r), 0, s & 1); er = r;
        if (o == OP_LSRA || o == OP_RORA) ea = r;
      end
      OP_INCM: begin er = (mm + 1) & 255; ep = zn(ep, er); end
      OP_DECM: begin er = (mm + 255) & 255; ep = zn(ep, er); end
      OP_INX: begin ex = (ex + 1) & 255; ep = zn(ep, ex); end
      OP_DEX: begin ex = (ex + 255) & 255; ep = zn(ep, ex); end
      OP_INY: begin ey = (ey + 1) & 255; ep = zn(ep, ey); end
      OP_DEY: begin ey = (ey + 255) & 255; ep = zn(ep, ey); end
      OP_CMP, OP_CPX, OP_CPY: begin
        s = (o == OP_CPX) ? ex : (o == OP_CPY) ? ey : ea;
        ep = put(zn(ep, (s - mm) & 255), 0, s >= mm);
      end
      OP_BIT: begin ep = put(put(put(ep, 1, (ea & mm) == 0), 7, mm >> 7), 6, (mm >> 6) & 1); end
      OP_LDA, OP_PLA: begin ea = mm; er = mm; ep = zn(ep, mm); end
      OP_LDX, OP_TSX: begin ex = mm; ep = zn(ep, mm); end
      OP_LDY: begin ey = mm; ep = zn(ep, mm); end
      OP_TAX: begin ex = ea; ep = zn(ep, ea); end
      OP_TAY: begin ey = ea; ep = zn(ep, ea); end
      OP_TXA: begin ea = ex; ep = zn(ep, ex); end
      OP_TYA: begin ea = ey; ep = zn(ep, ey); end
      OP_PHA, OP_STA: er = ea;
      OP_PLP, OP_RTI: ep = mm | 32;
      OP_BRK: ep = put(ep, 4, 1);
      OP_CLC: ep = put(ep, 0, 0);
      OP_SEC: ep = put(ep, 0, 1);
      OP_CLI: ep = put(ep, 2, 0);
      OP_SEI: ep = put(ep, 2, 1);
      OP_CLD: ep = put(ep, 3, 0);
      OP_SED: ep = put(ep, 3, 1);
      OP_CLV: ep = put(ep, 6, 0);
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    n_run++;
    if (res !== er[7:0] || st !== ep[7:0] || xo !== ex[7:0] || yo !== ey[7:0]) begin
      n_fail++;
      $display("FAIL %s: res/st/x/y actual %02h/%02h/%02h/%02h expected %02h/%02h/%02h/%02h",
               tag, res, st, xo, yo, er[7:0], ep[7:0], ex[7:0], ey[7:0]);
    end
  endtask

  task automatic step(bit e, int o, int mm);
    string tag;
    @(negedge clk);
    en = e; op = o[5:0]; m = mm[7:0];
    tag = tag_of(e, o);
    model(e, o, mm);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    repeat (2) @(negedge clk);
    ea = 0; ex = 0; ey = 0; er = 0; ep = 8'h22;
    compare("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5113);
    do_reset();
    // R3 binary add corners
    step(1, OP_LDA, 8'h7F); step(1, OP_CLC, 0); step(1, OP_ADC, 8'h01);
    step(1, OP_LDA, 8'hFF); step(1, OP_ADC, 8'h01);
    // R4 binary subtract corners
    step(1, OP_SEC, 0); step(1, OP_LDA, 8'h80); step(1, OP_SBC, 8'h01);
    step(1, OP_CLC, 0); step(1, OP_LDA, 8'h00); step(1, OP_SBC, 8'h00);
    // R5 decimal corners
    step(1, OP_SED, 0); step(1, OP_CLC, 0); step(1, OP_LDA, 8'h99); step(1, OP_ADC, 8'h01);
    step(1, OP_SEC, 0); step(1, OP_LDA, 8'h00); step(1, OP_SBC, 8'h01);
    step(1, OP_CLC, 0); step(1, OP_LDA, 8'h45); step(1, OP_SBC, 8'h17);
    step(1, OP_CLD, 0);
    // R9 compare corners
    step(1, OP_LDX, 8'h05); step(1, OP_CPX, 8'h05); step(1, OP_CPX, 8'h06);
    step(1, OP_LDY, 8'h80); step(1, OP_CPY, 8'h7F); step(1, OP_CMP, 8'hFF);
    // R10 bit test
    step(1, OP_LDA, 8'h3F); step(1, OP_BIT, 8'hC0); step(1, OP_BIT, 8'h01);
    // R13 status operations
    step(1, OP_PLP, 8'h00); step(1, OP_RTI, 8'hDF); step(1, OP_BRK, 0); step(1, OP_CLV, 0);
    // R8 index wrap, R12 push/store/pull, R7 rotate through carry
    step(1, OP_LDX, 8'h00); step(1, OP_DEX, 0); step(1, OP_INX, 0);
    step(1, OP_PHA, 0); step(1, OP_PLA, 8'h80); step(1, OP_STA, 0);
    step(1, OP_SEC, 0); step(1, OP_RORM, 8'h01); step(1, OP_ROLA, 0);
    // R2 disabled and unrecognised codes
    step(0, OP_LDA, 8'h55); step(1, 50, 8'h12); step(1, 63, 8'hFF);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int o;
      bit e;
      o = $urandom_range(0, 47);
      e = ($urandom_range(0, 7) != 0);
      step(e, o, $urandom_range(0, 255));
      if (i == 3000) do_reset();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule